// File: doc/BRIEF.md
# Key-Correlated Leakage Shift Register

This block is a single wide shift register whose contents follow secret key material, so that its switching activity and its bottom bit form a key-dependent signature. It sits beside a cipher core: it watches an activity flag and a per-round completion strobe and takes either the current round-key byte or the whole key. Its outputs are only observed; nothing feeds back into the cipher.

A parameter fixes one of three behaviours at build time:
- **Byte mode:** one round-key byte is pushed in for each completed round, and the register rotates on other active cycles.
- **Full-key mode:** the key is loaded when activity begins and then rotated out one bit per clock.
- **Rotate mode:** one trigger loads the key, and rotation then runs every cycle until reset, whatever the cipher does.

When the register is not in use it holds an alternating 0/1 idle pattern.

Top module: `keyleak_shreg`

## Requirements
- R1: A synchronous active-high reset sets the register to the idle pattern. The idle pattern is 0x55 repeated over the full width, so bit 0 is 1. In rotate mode the reset also clears the trigger latch.
- R2: In byte mode (MODE=0) and full-key mode (MODE=1), a clock edge that samples `active` low loads the idle pattern.
- R3: In byte mode, an edge that samples `active` and `round_done` both high shifts the register up by 8 bits and places `key_byte` in bits 7:0.
- R4: In byte mode, an edge that samples `active` high and `round_done` low rotates the register right by one bit, with old bit 0 moving into the top bit.
- R5: In full-key mode, the first edge that samples `active` high after an edge that sampled it low (or after reset) loads `key` into the register.
- R6: In full-key mode, every later edge with `active` still high rotates the register right by one bit. `round_done` has no effect in this mode.
- R7: In rotate mode (MODE=2), the first edge that samples `active` high loads `key` and sets a trigger latch. From the next edge on, the register rotates right by one bit every cycle, whatever `active` and `round_done` do, until reset.
- R8: In rotate mode, the register keeps the idle pattern until the trigger occurs.
- R9: `leak_bit` always equals bit 0 of `leak_reg`, and both are outputs of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| active | input | 1 | Cipher activity / trigger flag |
| round_done | input | 1 | Round-completion strobe (byte mode) |
| key_byte | input | BYTE_W | Current round-key byte |
| key | input | KEY_W | Full secret key |
| leak_bit | output | 1 | Register bit 0, the leakage output |
| leak_reg | output | KEY_W | Whole register, for observation |

## Verification
The full-key assertions assume `active` is low while reset is held, so that an activity edge seen right after reset is a real start. The bench holds `active` low on every reset cycle it drives, and keeps this even when a random reset lands in the middle of activity. The other checks assume no relation between `round_done` and `active`. The random stimulus therefore raises the strobe on its own in every mode, including while idle and after the rotate trigger has fired.

// File: rtl/keyleak_pkg.sv
package keyleak_pkg;

  typedef enum logic [1:0] {
    KL_BYTE   = 2'd0,
    KL_FULL   = 2'd1,
    KL_ROTATE = 2'd2
  } kl_mode_e;

  typedef enum logic [1:0] {
    ACT_IDLE      = 2'd0,
    ACT_LOAD_KEY  = 2'd1,
    ACT_LOAD_BYTE = 2'd2,
    ACT_ROTATE    = 2'd3
  } kl_act_e;

endpackage

// File: rtl/kl_ctrl.sv
module kl_ctrl
  import keyleak_pkg::*;
#(
  parameter kl_mode_e MODE = KL_BYTE
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    active,
  input  logic    round_done,
  output kl_act_e act,
  output logic    engaged
);

  // engaged: full mode = active seen last edge, rotate mode = sticky trigger
  always_ff @(posedge clk) begin
    if (rst) begin
      engaged <= 1'b0;
    end else begin
      case (MODE)
        KL_FULL:   engaged <= active;
        KL_ROTATE: engaged <= engaged | active;
        default:   engaged <= 1'b0;
      endcase
    end
  end

  always_comb begin
    act = ACT_IDLE;
    case (MODE)
      KL_BYTE: begin
        if (active) act = round_done ? ACT_LOAD_BYTE : ACT_ROTATE;
      end
      KL_FULL: begin
        if (active) act = engaged ? ACT_ROTATE : ACT_LOAD_KEY;
      end
      KL_ROTATE: begin
        if (engaged)     act = ACT_ROTATE;
        else if (active) act = ACT_LOAD_KEY;
      end
      default: act = ACT_IDLE;
    endcase
  end

endmodule

// File: rtl/kl_shifter.sv
module kl_shifter
  import keyleak_pkg::*;
#(
  parameter int KEY_W  = 128,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  kl_act_e           act,
  input  logic [KEY_W-1:0]  key,
  input  logic [BYTE_W-1:0] key_byte,
  output logic [KEY_W-1:0]  q
);

  localparam logic [KEY_W-1:0] IDLE_PAT = {(KEY_W/2){2'b01}};

  logic [KEY_W-1:0] q_next;

  always_comb begin
    case (act)
      ACT_LOAD_KEY:  q_next = key;
      ACT_LOAD_BYTE: q_next = {q[KEY_W-BYTE_W-1:0], key_byte};
      ACT_ROTATE:    q_next = {q[0], q[KEY_W-1:1]};
      default:       q_next = IDLE_PAT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= IDLE_PAT;
    else     q <= q_next;
  end

endmodule

// File: rtl/keyleak_shreg.sv
module keyleak_shreg
  import keyleak_pkg::*;
#(
  parameter int       KEY_W  = 128,
  parameter int       BYTE_W = 8,
  parameter kl_mode_e MODE   = KL_BYTE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              round_done,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic [KEY_W-1:0]  key,
  output logic              leak_bit,
  output logic [KEY_W-1:0]  leak_reg
);

  localparam logic [KEY_W-1:0] IDLE_PAT = {(KEY_W/2){2'b01}};

  kl_act_e act;
  logic    engaged;

  kl_ctrl #(.MODE(MODE)) u_ctrl (
    .clk(clk), .rst(rst), .active(active), .round_done(round_done),
    .act(act), .engaged(engaged)
  );

  kl_shifter #(.KEY_W(KEY_W), .BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .act(act), .key(key), .key_byte(key_byte),
    .q(leak_reg)
  );

  assign leak_bit = leak_reg[0];

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (leak_reg == IDLE_PAT));

  generate
    if (MODE == KL_BYTE) begin : g_chk_byte
      a_r2_idle_byte: assert property (@(posedge clk) disable iff (rst)
        !active |=> (leak_reg == IDLE_PAT));
      a_r3_byte_load: assert property (@(posedge clk) disable iff (rst)
        (active && round_done) |=>
          (leak_reg[BYTE_W-1:0] == $past(key_byte)) &&
          (leak_reg[KEY_W-1:BYTE_W] == $past(leak_reg[KEY_W-BYTE_W-1:0])));
      a_r4_byte_rot: assert property (@(posedge clk) disable iff (rst)
        (active && !round_done) |=>
          (leak_reg == {$past(leak_reg[0]), $past(leak_reg[KEY_W-1:1])}));
    end else if (MODE == KL_FULL) begin : g_chk_full
      a_r2_idle_full: assert property (@(posedge clk) disable iff (rst)
        !active |=> (leak_reg == IDLE_PAT));
      a_r5_full_load: assert property (@(posedge clk) disable iff (rst)
        (active && !engaged) |=> (leak_reg == $past(key)));
      a_r6_full_rot: assert property (@(posedge clk) disable iff (rst)
        (active && engaged) |=>
          (leak_reg == {$past(leak_reg[0]), $past(leak_reg[KEY_W-1:1])}));
    end else begin : g_chk_rot
      a_r7_rot_sticky: assert property (@(posedge clk) disable iff (rst)
        engaged |=> engaged &&
          (leak_reg == {$past(leak_reg[0]), $past(leak_reg[KEY_W-1:1])}));
      a_r8_rot_wait: assert property (@(posedge clk) disable iff (rst)
        (!engaged && !active) |=> (leak_reg == IDLE_PAT));
    end
  endgenerate

endmodule

// File: tb/tb_keyleak_shreg.sv
`timescale 1ns/1ps
module tb_keyleak_shreg;
  import keyleak_pkg::*;

  localparam int KW = 128;
  localparam int BW = 8;
  localparam logic [KW-1:0] IDLE = {(KW/2){2'b01}};

  logic clk = 1'b0;
  logic rst, active, round_done;
  logic [BW-1:0] key_byte;
  logic [KW-1:0] key;

  logic          lb_b, lb_f, lb_r;
  logic [KW-1:0] lr_b, lr_f, lr_r;

  keyleak_shreg #(.KEY_W(KW), .BYTE_W(BW), .MODE(KL_BYTE)) dut (
    .clk(clk), .rst(rst), .active(active), .round_done(round_done),
    .key_byte(key_byte), .key(key), .leak_bit(lb_b), .leak_reg(lr_b));
  keyleak_shreg #(.KEY_W(KW), .BYTE_W(BW), .MODE(KL_FULL)) dut_full (
    .clk(clk), .rst(rst), .active(active), .round_done(round_done),
    .key_byte(key_byte), .key(key), .leak_bit(lb_f), .leak_reg(lr_f));
  keyleak_shreg #(.KEY_W(KW), .BYTE_W(BW), .MODE(KL_ROTATE)) dut_rot (
    .clk(clk), .rst(rst), .active(active), .round_done(round_done),
    .key_byte(key_byte), .key(key), .leak_bit(lb_r), .leak_reg(lr_r));

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  bit valid = 1'b0;

  logic [KW-1:0] m_b, m_f, m_r;
  logic e_f, e_r;
  string t_b, t_f, t_r;

  function automatic logic [KW-1:0] rotr(input logic [KW-1:0] v);
    return {v[0], v[KW-1:1]};
  endfunction

  task automatic model(input int mode, input logic [KW-1:0] cur, input logic eng,
                       output logic [KW-1:0] nx, output logic neng, output string tg);
    neng = 1'b0;
    if (rst) begin
      nx = IDLE; tg = "R1";
    end else if (mode == 0) begin
      if (!active)        begin nx = IDLE; tg = "R2"; end
      else if (round_done) begin nx = {cur[KW-BW-1:0], key_byte}; tg = "R3"; end
      else                begin nx = rotr(cur); tg = "R4"; end
    end else if (mode == 1) begin
      neng = active;
      if (!active)   begin nx = IDLE; tg = "R2"; end
      else if (!eng) begin nx = key; tg = "R5"; end
      else           begin nx = rotr(cur); tg = "R6"; end
    end else begin
      neng = eng | active;
      if (eng)         begin nx = rotr(cur); tg = "R7"; end
      else if (active) begin nx = key; tg = "R7"; end
      else             begin nx = IDLE; tg = "R8"; end
    end
  endtask

  task automatic chk(input string who, input string tg, input logic [KW-1:0] got,
                     input logic [KW-1:0] exp, input logic gbit);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s leak_reg actual=%h expected=%h", who, tg, got, exp);
    end
    n_chk++;
    if (gbit !== exp[0]) begin
      n_err++;
      $display("FAIL %s R9 leak_bit actual=%b expected=%b", who, gbit, exp[0]);
    end
  endtask

  task automatic cyc(input logic r, input logic a, input logic rd,
                     input logic [BW-1:0] kb, input logic [KW-1:0] k);
    logic [KW-1:0] nx;
    logic ne;
    string tg;
    @(negedge clk);
    if (valid) begin
      chk("byte", t_b, lr_b, m_b, lb_b);
      chk("full", t_f, lr_f, m_f, lb_f);
      chk("rot",  t_r, lr_r, m_r, lb_r);
    end
    rst = r; active = a; round_done = rd; key_byte = kb; key = k;
    model(0, m_b, 1'b0, nx, ne, tg); m_b = nx; t_b = tg;
    model(1, m_f, e_f, nx, ne, tg);  m_f = nx; e_f = ne; t_f = tg;
    model(2, m_r, e_r, nx, ne, tg);  m_r = nx; e_r = ne; t_r = tg;
    valid = 1'b1;
  endtask

  function automatic logic [KW-1:0] rkey();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [KW-1:0] k1;
    void'($urandom(32'd20240611));
    rst = 1'b1; active = 1'b0; round_done = 1'b0; key_byte = '0; key = '0;
    e_f = 1'b0; e_r = 1'b0;
    // R1 reset, then idle R2/R8 with strobe that must be ignored
    repeat (3) cyc(1'b1, 1'b0, 1'b0, 8'h00, '0);
    cyc(1'b0, 1'b0, 1'b1, 8'hA5, rkey());
    cyc(1'b0, 1'b0, 1'b0, 8'h3C, rkey());
    // activity start: R5 load, R7 trigger, R4 byte rotation
    k1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    repeat (5) cyc(1'b0, 1'b1, 1'b0, 8'h11, k1);
    // R3 byte loads, R6 rotation ignores strobe
    cyc(1'b0, 1'b1, 1'b1, 8'hDE, rkey());
    cyc(1'b0, 1'b1, 1'b1, 8'hAD, rkey());
    cyc(1'b0, 1'b1, 1'b1, 8'hFF, rkey());
    // active drops: R2 idle, R7 keeps rotating
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 8'h00, rkey());
    repeat (2) cyc(1'b0, 1'b1, 1'b0, 8'h77, rkey());
    cyc(1'b1, 1'b0, 1'b0, 8'h00, '0);
    cyc(1'b0, 1'b0, 1'b0, 8'h00, '0);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic r;
      r = (($urandom % 300) == 0);
      cyc(r, r ? 1'b0 : (($urandom % 8) != 0), (($urandom % 4) == 0),
          8'($urandom), rkey());
    end
    cyc(1'b0, 1'b0, 1'b0, 8'h00, '0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule